// File: doc/BRIEF.md
# Double-Buffered Block Transfer Between Clock Domains

This block moves a stream of data words from a source clock domain to an unrelated destination clock domain. It does not synchronise every word. Words are gathered into fixed-size blocks held in two banks of flip-flop storage. Crossing domains costs one synchronised notification per block, and every word in the block shares that cost.

The writer fills one bank through a valid/ready port. When the bank holds a full block, the writer flips that bank's "filled" toggle and moves on to the other bank. The toggle reaches the destination domain through a two-flop synchroniser. The reader then presents the block on its own valid/ready port, one word per accepted cycle. It marks the final word of the block and flips that bank's "released" toggle, which travels back the same way.

While one bank is handed over and drained, the writer fills the other bank, so filling and draining overlap. The first word of a block reaches the reader only after the whole block has been written and the notice has crossed domains. After that, the rest of the block follows with no gaps.

Top module: `burst_bank_cdc`

## Requirements
- R1: After reset, `wr_ready` is 1 and `rd_valid` is 0.
- R2: With no reads, the writer accepts exactly 2*DEPTH words. It then holds `wr_ready` low.
- R3: No word of a block is visible at the read port until all DEPTH words of that block have been accepted. `rd_valid` stays 0 while a block is only partly written.
- R4: For any ratio of the two clock frequencies, words leave the read port in the order they were accepted, with none lost and none duplicated. Banks drain in the order they were filled.
- R5: `rd_last` is 1 exactly on the final word of each block, the word at position DEPTH-1 counted from 0 within its block. `rd_last` is never 1 while `rd_valid` is 0.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_last` hold their values.
- R7: Once the reader has taken the last word of a bank, `wr_ready` returns to 1 within a few source clock cycles if the writer was waiting for that bank.
- R8: A write presented while `wr_ready` is 0 is ignored. Its data never appears at the read port and does not change the count of words delivered.
- R9: Within a block, after a word with `rd_last` = 0 is accepted, `rd_valid` is 1 on the next destination cycle. The rest of a block is never interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source domain clock |
| wr_rst | input | 1 | Source domain synchronous reset, active high |
| wr_valid | input | 1 | Source offers a word |
| wr_ready | output | 1 | Writer can accept a word into the current bank |
| wr_data | input | DW | Word being written |
| rd_clk | input | 1 | Destination domain clock |
| rd_rst | input | 1 | Destination domain synchronous reset, active high |
| rd_valid | output | 1 | A word from a handed-over bank is presented |
| rd_ready | input | 1 | Destination accepts the presented word |
| rd_data | output | DW | Presented word |
| rd_last | output | 1 | Presented word is the final one of its block |

## Verification
Some properties are local to one domain, and the assertions check these on every clock:
- pointers and bank selects freeze under a refused write;
- a bank is handed over only from its final slot;
- a stalled output holds still;
- `rd_last` never appears without `rd_valid`;
- a block drains without gaps.

Other behaviour involves both domains and shows up only in the bench scenarios:
- ordering, loss and duplication across clock ratios faster and slower than the source;
- the invisibility of a partly written block;
- the two-bank capacity limit;
- the writer reopening once a bank is released.

// File: rtl/burst_bank_cdc_pkg.sv
package burst_bank_cdc_pkg;
  localparam int NBANK = 2;
  typedef logic [NBANK-1:0] bank_flags_t;
endpackage

// File: rtl/bbc_toggle_sync.sv
module bbc_toggle_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bbc_wr_ctrl.sv
module bbc_wr_ctrl
  import burst_bank_cdc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  bank_flags_t   free_tgl_s,
  output bank_flags_t   fill_tgl,
  output logic          we,
  output logic          wbank,
  output logic [AW-1:0] waddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // A bank is busy while its fill toggle and release toggle differ.
  assign wr_ready = (fill_tgl[wbank] == free_tgl_s[wbank]);
  assign we       = wr_valid & wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_tgl <= '0;
      wbank    <= 1'b0;
      waddr    <= '0;
    end else if (we) begin
      if (waddr == LAST) begin
        waddr           <= '0;
        fill_tgl[wbank] <= ~fill_tgl[wbank];
        wbank           <= ~wbank;
      end else begin
        waddr <= waddr + 1'b1;
      end
    end
  end

  // R8
  refused_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> ($stable(waddr) && $stable(wbank) && $stable(fill_tgl)));

  // R3
  whole_block_handover_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_tgl != $past(fill_tgl)) |-> ($past(waddr) == LAST && $past(we)));
endmodule

// File: rtl/bbc_rd_ctrl.sv
module bbc_rd_ctrl
  import burst_bank_cdc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_last,
  input  bank_flags_t   fill_tgl_s,
  output bank_flags_t   free_tgl,
  output logic          rbank,
  output logic [AW-1:0] raddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic take;

  // A bank is readable while the synchronised fill toggle differs from the local release toggle.
  assign rd_valid = (fill_tgl_s[rbank] != free_tgl[rbank]);
  assign rd_last  = rd_valid & (raddr == LAST);
  assign take     = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_tgl <= '0;
      rbank    <= 1'b0;
      raddr    <= '0;
    end else if (take) begin
      if (raddr == LAST) begin
        raddr           <= '0;
        free_tgl[rbank] <= ~free_tgl[rbank];
        rbank           <= ~rbank;
      end else begin
        raddr <= raddr + 1'b1;
      end
    end
  end

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  // R9
  block_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !rd_last) |=> rd_valid);

  // R6
  stall_hold_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(raddr) && $stable(rbank)));
endmodule

// File: rtl/burst_bank_cdc.sv
module burst_bank_cdc
  import burst_bank_cdc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int SYNC  = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);
  localparam int AW    = $clog2(DEPTH);
  localparam int WORDS = NBANK * DEPTH;
  localparam int IW    = $clog2(WORDS);

  bank_flags_t   fill_tgl, fill_tgl_s, free_tgl, free_tgl_s;
  logic          we, wbank, rbank;
  logic [AW-1:0] waddr, raddr;
  logic [IW-1:0] widx, ridx;
  logic [DW-1:0] store [WORDS];

  bbc_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .free_tgl_s(free_tgl_s), .fill_tgl(fill_tgl), .we(we),
    .wbank(wbank), .waddr(waddr)
  );

  bbc_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_last(rd_last), .fill_tgl_s(fill_tgl_s), .free_tgl(free_tgl),
    .rbank(rbank), .raddr(raddr)
  );

  bbc_toggle_sync #(.W(NBANK), .STAGES(SYNC)) u_fill_sync (
    .clk(rd_clk), .rst(rd_rst), .d(fill_tgl), .q(fill_tgl_s)
  );

  bbc_toggle_sync #(.W(NBANK), .STAGES(SYNC)) u_free_sync (
    .clk(wr_clk), .rst(wr_rst), .d(free_tgl), .q(free_tgl_s)
  );

  assign widx = IW'(wbank) * IW'(DEPTH) + IW'(waddr);
  assign ridx = IW'(rbank) * IW'(DEPTH) + IW'(raddr);

  // Storage: written only in the source domain; a bank is read only while the writer is locked out of it.
  always_ff @(posedge wr_clk) begin
    if (we) store[widx] <= wr_data;
  end

  assign rd_data = store[ridx];

  // R6
  stall_data_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_valid && !rd_ready) |=> ($stable(rd_data) && $stable(rd_last)));
endmodule

// File: tb/burst_bank_cdc_tb.sv
`timescale 1ns/1ps
module burst_bank_cdc_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  typedef struct packed {
    int unsigned rd_half_ps;
    int unsigned blocks;
    int unsigned wr_gap;
    int unsigned rd_gap;
    int unsigned exp_lasts;
  } row_t;

  localparam int ROWS = 5;
  localparam row_t TABLE [ROWS] = '{
    '{rd_half_ps: 1700, blocks: 4, wr_gap: 0, rd_gap: 0, exp_lasts: 4},
    '{rd_half_ps: 6300, blocks: 5, wr_gap: 0, rd_gap: 0, exp_lasts: 5},
    '{rd_half_ps: 2300, blocks: 3, wr_gap: 3, rd_gap: 4, exp_lasts: 3},
    '{rd_half_ps: 9100, blocks: 4, wr_gap: 2, rd_gap: 3, exp_lasts: 4},
    '{rd_half_ps: 1300, blocks: 6, wr_gap: 0, rd_gap: 5, exp_lasts: 6}
  };

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst = 1, rd_rst = 1;
  logic          wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  realtime       rd_half = 3.1;
  int            checks = 0, fails = 0;
  bit            done = 0;

  burst_bank_cdc #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
  );

  always #2.5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge wr_clk);
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] d, output logic l);
    @(negedge rd_clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge rd_clk);
    d = rd_data;
    l = rd_last;
    @(negedge rd_clk);
    rd_ready = 1'b0;
  endtask

  task automatic run_row(input int r);
    int total = int'(TABLE[r].blocks) * DEPTH;
    int lasts = 0;
    rd_half = TABLE[r].rd_half_ps / 1000.0;
    fork
      begin : producer
        int i = 0, cyc = 0;
        bit fire = 0;
        while (i < total) begin
          @(negedge wr_clk);
          cyc++;
          if (fire) i++;
          if (i < total && (TABLE[r].wr_gap == 0 || cyc % TABLE[r].wr_gap != 0)) begin
            wr_valid = 1'b1;
            wr_data  = DW'((r << 12) | i);
          end else begin
            wr_valid = 1'b0;
          end
          fire = wr_valid && wr_ready;
        end
        wr_valid = 1'b0;
      end
      begin : consumer
        int j = 0, cyc = 0;
        bit run_on = 0;
        while (j < total) begin
          @(negedge rd_clk);
          cyc++;
          // R9: a block continues without gaps once started
          if (run_on) check(rd_valid, "R9 gap inside block", rd_valid, 1);
          rd_ready = (TABLE[r].rd_gap == 0 || cyc % TABLE[r].rd_gap != 0);
          run_on = 0;
          if (rd_valid && rd_ready) begin
            // R4: order, no loss, no duplicate
            check(rd_data == DW'((r << 12) | j), "R4 word order", rd_data, (r << 12) | j);
            // R5: last on final word of each block
            check(rd_last == (j % DEPTH == DEPTH - 1), "R5 last flag", rd_last, (j % DEPTH == DEPTH - 1));
            if (rd_last) lasts++;
            run_on = !rd_last;
            j++;
          end
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
      end
    join
    check(lasts == int'(TABLE[r].exp_lasts), "R5 block count", lasts, TABLE[r].exp_lasts);
    repeat (12) @(negedge rd_clk);
    check(!rd_valid, "R4 no extra word", rd_valid, 0);
  endtask

  initial begin
    #500us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic          l;
    bit            seen;
    #60;
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    @(negedge wr_clk);
    // R1
    check(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    @(negedge rd_clk);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

    for (int r = 0; r < ROWS; r++) run_row(r);

    rd_half = 3.1;
    repeat (4) @(negedge rd_clk);
    // R3: partial block stays hidden
    for (int k = 0; k < DEPTH - 1; k++) push(DW'(16'hA000 + k));
    repeat (20) @(negedge rd_clk);
    check(!rd_valid, "R3 partial block hidden", rd_valid, 0);
    push(DW'(16'hA000 + DEPTH - 1));
    repeat (10) @(negedge rd_clk);
    check(rd_valid, "R3 full block visible", rd_valid, 1);
    check(rd_data == 16'hA000, "R3 first word", rd_data, 16'hA000);

    // R6: stall holds data
    seen = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge rd_clk);
      if (!(rd_valid && rd_data == 16'hA000 && !rd_last)) seen = 0;
    end
    check(seen, "R6 stalled output holds", seen, 1);

    // R2: second bank fills, then writer blocks
    for (int k = 0; k < DEPTH; k++) push(DW'(16'hB000 + k));
    @(negedge wr_clk);
    check(!wr_ready, "R2 full after two banks", wr_ready, 0);

    // R8: writes while blocked are ignored
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = 16'hDEAD;
    repeat (10) @(negedge wr_clk);
    wr_valid = 1'b0;
    check(!wr_ready, "R2 still blocked", wr_ready, 0);

    // R7: drain first bank, writer reopens
    for (int k = 0; k < DEPTH; k++) begin
      pop(d, l);
      check(d == DW'(16'hA000 + k), "R4 first bank order", d, 16'hA000 + k);
    end
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge wr_clk);
      if (wr_ready) seen = 1;
    end
    check(seen, "R7 writer reopens after release", seen, 1);

    // R8: second bank holds only the accepted words
    for (int k = 0; k < DEPTH; k++) begin
      pop(d, l);
      check(d == DW'(16'hB000 + k), "R8 no refused word stored", d, 16'hB000 + k);
      check(l == (k == DEPTH - 1), "R5 last in directed drain", l, (k == DEPTH - 1));
    end
    repeat (20) @(negedge rd_clk);
    check(!rd_valid, "R8 nothing left after drain", rd_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule